// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM built from byte lanes. It samples a command on every rising clock edge where clock enable is active: chip selects, load/advance control, read/write select, address and per-lane write enables. The data transfer for that command happens two clock edges later on registered paths. Because reads and writes both run with the same two-edge delay, they can follow each other on consecutive edges with no idle turnaround cycle.

A load cycle starts an access at a new address. Later cycles with the load control high continue that access as a four-beat burst over the two low address bits. The burst runs in linear or interleaved order, chosen by a static mode input. A high clock-enable input freezes every register, so that edge has no effect at all. Deselect cycles let the data output go quiet two edges later. An asynchronous output enable gates the read data drive. The data bus is split into separate input, output and drive-enable signals.

Top module: `zt_sram`

## Requirements
- R1: While reset is asserted, and after it is released until a read reaches its data phase, `dout_oe` is low. An asynchronous reset clears the pipeline at once.
- R2: Read data for a read command sampled at edge N is registered at edge N+2. It is presented on `dout` with `dout_oe` high until the next enabled edge.
- R3: Write data for a write command sampled at edge N is taken from `din` at edge N+2. Reads and writes may be issued on consecutive edges with no idle cycle, and a read issued right after a write returns the written data.
- R4: `byte_we_n[i]` is sampled with each write command. When it is 1, lane i (bits [8i+7:8i]) of the addressed word keeps its old content. When it is 0, that lane takes the new data.
- R5: An enabled edge with `load_n` = 1 continues the access in progress. It ignores `addr`, `rd_wr_n` and the chip selects. It keeps the read/write type and the upper address bits, and it advances the burst counter by one.
- R6: With `ilv_mode` = 0, the two low address bits of burst beat n are (start + n) mod 4.
- R7: With `ilv_mode` = 1, the two low address bits of burst beat n are start XOR n.
- R8: The chip is selected only when `sel_a_n` = 0, `sel_b_n` = 0 and `sel_c` = 1. Any other combination, sampled with `load_n` = 0, is a deselect cycle, and `dout_oe` is low two edges later. Advance cycles that follow a deselect are also deselects.
- R9: When `clk_en_n` = 1 at an edge, no register, memory word or output changes, and the pipeline resumes afterwards as if that edge had not occurred.
- R10: `out_en_n` = 1 forces `dout_oe` low combinationally, with no clock edge needed. Returning it to 0 restores the drive of pending read data at once. `rd_wr_n` = 1 selects read and 0 selects write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| load_n | input | 1 | Low loads a new command, high advances the burst |
| rd_wr_n | input | 1 | 1 = read, 0 = write, taken on load cycles |
| addr | input | AW | Word address, taken on load cycles |
| byte_we_n | input | NL | Active-low write enable per byte lane |
| ilv_mode | input | 1 | Static burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| din | input | NL*LW | Write data, sampled in the data phase |
| dout | output | NL*LW | Registered read data |
| dout_oe | output | 1 | High when `dout` should drive the bus |

## Verification
The hardest state to reach is a clock-enable stall that lands in the middle of a read burst, while earlier reads are still inside the two-stage pipeline. One frozen edge has to hold the output, hold the burst counter and hold both pipeline stages at the same time. The stimulus table places the stall right after the first burst read data appears. The expected data on the following edges then shifts by exactly one cycle, and the next burst beat continues from the frozen count. A lane-masked write into a word that was already written in a burst, and a deselected load followed by an advance, are also placed in the table, so that their effects show up in later read data.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  // Low two address bits of burst beat cnt from start offset.
  function automatic logic [1:0] burst_off(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
    burst_off = ilv ? (start ^ cnt) : (start + cnt);
  endfunction

endpackage

// File: rtl/zt_cmd_front.sv
module zt_cmd_front
  import zt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic          sel,
  input  logic          load,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [NL-1:0] ben,
  input  logic          ilv,
  output logic          s1_vld,
  output logic          s1_wr,
  output logic [AW-1:0] s1_addr,
  output logic [NL-1:0] s1_ben
);

  logic          vld_q, vld_d;
  logic          wr_q, wr_d;
  logic [AW-3:0] base_q, base_d;
  logic [1:0]    start_q, start_d;
  logic [1:0]    cnt_q, cnt_d;
  logic [NL-1:0] ben_q, ben_d;

  always_comb begin
    vld_d   = vld_q;
    wr_d    = wr_q;
    base_d  = base_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    ben_d   = ben_q;
    if (cke) begin
      ben_d = ben;
      if (load) begin
        vld_d = sel;
        if (sel) begin
          wr_d    = ~rd;
          base_d  = addr[AW-1:2];
          start_d = addr[1:0];
          cnt_d   = 2'd0;
        end
      end else begin
        cnt_d = cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      wr_q    <= 1'b0;
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      ben_q   <= '1;
    end else begin
      vld_q   <= vld_d;
      wr_q    <= wr_d;
      base_q  <= base_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      ben_q   <= ben_d;
    end
  end

  assign s1_vld  = vld_q;
  assign s1_wr   = wr_q;
  assign s1_addr = {base_q, burst_off(start_q, cnt_q, ilv)};
  assign s1_ben  = ben_q;

  // R5
  adv_keeps_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !load) |=> (s1_wr == $past(s1_wr)) && (s1_vld == $past(s1_vld))
                       && (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));

  // R6
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !load && !ilv) |=> (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1));

endmodule

// File: rtl/zt_pipe_reg.sv
module zt_pipe_reg #(
  parameter int AW = 6,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic          i_vld,
  input  logic          i_wr,
  input  logic [AW-1:0] i_addr,
  input  logic [NL-1:0] i_ben,
  output logic          o_vld,
  output logic          o_wr,
  output logic [AW-1:0] o_addr,
  output logic [NL-1:0] o_ben
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld  <= 1'b0;
      o_wr   <= 1'b0;
      o_addr <= '0;
      o_ben  <= '1;
    end else if (cke) begin
      o_vld  <= i_vld;
      o_wr   <= i_wr;
      o_addr <= i_addr;
      o_ben  <= i_ben;
    end
  end

endmodule

// File: rtl/zt_store.sv
module zt_store #(
  parameter int AW = 6,
  parameter int NL = 2,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             s2_vld,
  input  logic             s2_wr,
  input  logic [AW-1:0]    s2_addr,
  input  logic [NL-1:0]    s2_ben,
  input  logic [NL*LW-1:0] din,
  output logic [NL*LW-1:0] dout_q,
  output logic             rd_vld_q
);

  localparam int DEPTH = 1 << AW;

  logic             do_rd;
  logic             rd_vld_d;
  logic [NL*LW-1:0] rd_word;
  logic [NL*LW-1:0] dout_d;

  assign do_rd = s2_vld && !s2_wr;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] mem_l [DEPTH];
    always_ff @(posedge clk) begin
      if (cke && s2_vld && s2_wr && !s2_ben[g])
        mem_l[s2_addr] <= din[g*LW +: LW];
    end
    assign rd_word[g*LW +: LW] = mem_l[s2_addr];
  end

  always_comb begin
    rd_vld_d = rd_vld_q;
    dout_d   = dout_q;
    if (cke) begin
      rd_vld_d = do_rd;
      if (do_rd) dout_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q <= 1'b0;
      dout_q   <= '0;
    end else begin
      rd_vld_q <= rd_vld_d;
      dout_q   <= dout_d;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(dout_q) && $stable(rd_vld_q));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !s2_vld) |=> !rd_vld_q);

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW = 6,
  parameter int NL = 2,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic             sel_c,
  input  logic             load_n,
  input  logic             rd_wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [NL-1:0]    byte_we_n,
  input  logic             ilv_mode,
  input  logic             out_en_n,
  input  logic [NL*LW-1:0] din,
  output logic [NL*LW-1:0] dout,
  output logic             dout_oe
);

  logic [1:0]    rst_sync_q;
  logic          rst_sn;
  logic          cke;
  logic          s1_vld, s1_wr, s2_vld, s2_wr;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [NL-1:0] s1_ben, s2_ben;
  logic          rd_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];
  assign cke    = ~clk_en_n;

  zt_cmd_front #(.AW(AW), .NL(NL)) u_front (
    .clk(clk), .rst_n(rst_sn), .cke(cke),
    .sel(!sel_a_n && !sel_b_n && sel_c), .load(!load_n), .rd(rd_wr_n),
    .addr(addr), .ben(byte_we_n), .ilv(ilv_mode),
    .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr), .s1_ben(s1_ben)
  );

  zt_pipe_reg #(.AW(AW), .NL(NL)) u_stage2 (
    .clk(clk), .rst_n(rst_sn), .cke(cke),
    .i_vld(s1_vld), .i_wr(s1_wr), .i_addr(s1_addr), .i_ben(s1_ben),
    .o_vld(s2_vld), .o_wr(s2_wr), .o_addr(s2_addr), .o_ben(s2_ben)
  );

  zt_store #(.AW(AW), .NL(NL), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_sn), .cke(cke),
    .s2_vld(s2_vld), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_ben(s2_ben),
    .din(din), .dout_q(dout), .rd_vld_q(rd_vld)
  );

  assign dout_oe = rd_vld & ~out_en_n;

  // R2
  read_lands_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (cke && s2_vld && !s2_wr) |=> rd_vld);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sn |-> !dout_oe);

endmodule

// File: tb/zt_sram_tb.sv
module zt_sram_tb;

  localparam int AW = 6, NL = 2, LW = 8, DW = NL*LW;

  typedef struct packed {
    logic          ck;   // 1 = stall
    logic [1:0]    ce;   // 0 sel, 1 sel_a_n hi, 2 sel_b_n hi, 3 sel_c lo
    logic          ld;   // load_n
    logic          rd;
    logic [AW-1:0] a;
    logic [NL-1:0] be;
    logic [DW-1:0] wd;
    logic          eo;
    logic [DW-1:0] ed;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'd0, 1'b0, 1'b0, 6'h08, 2'b00, 16'h0000, 1'b0, 16'h0000}, // R3 burst write
    '{1'b0, 2'd0, 1'b1, 1'b0, 6'h00, 2'b00, 16'h0000, 1'b0, 16'h0000}, // R5
    '{1'b0, 2'd0, 1'b1, 1'b1, 6'h3F, 2'b00, 16'h1111, 1'b0, 16'h0000}, // R5 ignored
    '{1'b0, 2'd0, 1'b1, 1'b0, 6'h00, 2'b00, 16'h2222, 1'b0, 16'h0000},
    '{1'b0, 2'd0, 1'b1, 1'b0, 6'h00, 2'b00, 16'h3333, 1'b0, 16'h0000}, // R6 wrap
    '{1'b0, 2'd0, 1'b0, 1'b1, 6'h0A, 2'b00, 16'h4444, 1'b0, 16'h0000},
    '{1'b0, 2'd0, 1'b0, 1'b1, 6'h0B, 2'b00, 16'h5555, 1'b0, 16'h0000},
    '{1'b0, 2'd0, 1'b0, 1'b0, 6'h09, 2'b01, 16'h0000, 1'b1, 16'h3333}, // R2 R4
    '{1'b0, 2'd0, 1'b0, 1'b1, 6'h08, 2'b00, 16'h0000, 1'b1, 16'h4444},
    '{1'b0, 2'd0, 1'b0, 1'b1, 6'h09, 2'b00, 16'hABCD, 1'b0, 16'h0000},
    '{1'b0, 2'd1, 1'b0, 1'b1, 6'h00, 2'b00, 16'h0000, 1'b1, 16'h5555}, // R8
    '{1'b0, 2'd0, 1'b1, 1'b1, 6'h00, 2'b00, 16'h0000, 1'b1, 16'hAB22}, // R4 R8
    '{1'b0, 2'd0, 1'b0, 1'b1, 6'h0A, 2'b00, 16'h0000, 1'b0, 16'h0000},
    '{1'b0, 2'd0, 1'b1, 1'b0, 6'h00, 2'b00, 16'h0000, 1'b0, 16'h0000},
    '{1'b0, 2'd0, 1'b1, 1'b0, 6'h00, 2'b00, 16'h0000, 1'b1, 16'h3333},
    '{1'b1, 2'd3, 1'b0, 1'b0, 6'h00, 2'b00, 16'hFFFF, 1'b1, 16'h3333}, // R9
    '{1'b0, 2'd0, 1'b1, 1'b0, 6'h00, 2'b00, 16'h0000, 1'b1, 16'h4444},
    '{1'b0, 2'd2, 1'b0, 1'b1, 6'h00, 2'b00, 16'h0000, 1'b1, 16'h5555},
    '{1'b0, 2'd3, 1'b0, 1'b1, 6'h00, 2'b00, 16'h0000, 1'b1, 16'hAB22},
    '{1'b0, 2'd3, 1'b0, 1'b1, 6'h00, 2'b00, 16'h0000, 1'b0, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en_n = 1'b0, sel_a_n = 1'b1, sel_b_n = 1'b1, sel_c = 1'b0;
  logic          load_n = 1'b0, rd_wr_n = 1'b1, ilv_mode = 1'b0, out_en_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] byte_we_n = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;
  int            n_chk = 0, n_fail = 0;
  logic          done = 1'b0;

  always #2.5 clk = ~clk;

  zt_sram #(.AW(AW), .NL(NL), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
    .sel_b_n(sel_b_n), .sel_c(sel_c), .load_n(load_n), .rd_wr_n(rd_wr_n),
    .addr(addr), .byte_we_n(byte_we_n), .ilv_mode(ilv_mode),
    .out_en_n(out_en_n), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic step(input logic ck, input logic [1:0] ce, input logic ld,
                      input logic rd, input logic [AW-1:0] a,
                      input logic [NL-1:0] be, input logic [DW-1:0] wd);
    @(negedge clk);
    clk_en_n  = ck;
    sel_a_n   = (ce == 2'd1);
    sel_b_n   = (ce == 2'd2);
    sel_c     = (ce != 2'd3);
    load_n    = ld;
    rd_wr_n   = rd;
    addr      = a;
    byte_we_n = be;
    din       = wd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 oe in reset", {15'd0, dout_oe}, 16'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R1 oe after reset", {15'd0, dout_oe}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].ck, TBL[i].ce, TBL[i].ld, TBL[i].rd, TBL[i].a, TBL[i].be, TBL[i].wd);
      chk($sformatf("R2/R3/R8/R9 vec %0d oe", i), {15'd0, dout_oe}, {15'd0, TBL[i].eo});
      if (TBL[i].eo) chk($sformatf("R2/R4/R6 vec %0d data", i), dout, TBL[i].ed);
    end

    // R7 interleaved burst from offset 1: 9, 8, B, A
    @(negedge clk) ilv_mode = 1'b1;
    step(1'b0, 2'd0, 1'b0, 1'b1, 6'h09, 2'b00, 16'h0);
    step(1'b0, 2'd0, 1'b1, 1'b0, 6'h00, 2'b00, 16'h0);
    step(1'b0, 2'd0, 1'b1, 1'b0, 6'h00, 2'b00, 16'h0);
    chk("R7 beat0 oe", {15'd0, dout_oe}, 16'd1);
    chk("R7 beat0", dout, 16'hAB22);
    step(1'b0, 2'd0, 1'b1, 1'b0, 6'h00, 2'b00, 16'h0);
    chk("R7 beat1", dout, 16'h5555);
    step(1'b0, 2'd3, 1'b0, 1'b1, 6'h00, 2'b00, 16'h0);
    chk("R7 beat2", dout, 16'h4444);
    out_en_n = 1'b1;
    #1 chk("R10 oe forced low", {15'd0, dout_oe}, 16'd0);
    out_en_n = 1'b0;
    #1 chk("R10 oe restored", {15'd0, dout_oe}, 16'd1);
    step(1'b0, 2'd3, 1'b0, 1'b1, 6'h00, 2'b00, 16'h0);
    chk("R7 beat3", dout, 16'h3333);
    step(1'b0, 2'd3, 1'b0, 1'b1, 6'h00, 2'b00, 16'h0);
    chk("R8 quiet after burst", {15'd0, dout_oe}, 16'd0);

    // R1 asynchronous reset while a read is in flight
    @(negedge clk) ilv_mode = 1'b0;
    step(1'b0, 2'd0, 1'b0, 1'b1, 6'h0B, 2'b00, 16'h0);
    step(1'b0, 2'd3, 1'b0, 1'b1, 6'h00, 2'b00, 16'h0);
    step(1'b0, 2'd3, 1'b0, 1'b1, 6'h00, 2'b00, 16'h0);
    chk("R2 late read", dout, 16'h4444);
    #0.5 rst_n = 1'b0;
    #0.5 chk("R1 async clear", {15'd0, dout_oe}, 16'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule